// File: doc/BRIEF.md
# Clock-Crossing Single-Transaction Memory Bridge

This bridge connects a CPU clock domain to a memory clock domain whose clock has no fixed relation to the CPU clock. It carries one read or write from the CPU side to the memory side and returns the outcome. The CPU clock is usually the faster of the two, but either clock may be faster. Each side runs a four-state controller. Its state register is passed to the other domain through a chain of synchronizer flops. In both controllers the state codes form a cyclic Gray sequence, so a synchronized sample always reads as either the previous state or the next one.

The CPU posts a request by raising `cpu_req` for one cycle while `cpu_busy` is low. The bridge latches the address, write data, size and direction at that moment. The memory side waits until its synchronized copy of the CPU state shows the posted request, then copies the latched payload. It presents the command and holds it until the memory accepts it. For a read, it also waits for the returned data. When the access is finished, the memory side enters a done state. The CPU side sees that state, takes the read data, pulses `cpu_done` and moves to an acknowledge state. The memory side then releases, and the CPU side returns to idle once it sees the memory side idle again. This four-phase exchange adds several cycles of latency. In return, every multi-bit bus is sampled only while its source is known to be holding it.

Top module: `mem_xing_bridge`

## Requirements
- R1: While reset is applied and immediately after it, `cpu_busy`, `cpu_done` and `mem_cmd_valid` are 0 and `cpu_rdata` is 0.
- R2: A request with `cpu_we`=0 produces exactly one memory command with `mem_cmd_we`=0 and the posted address and size. After that, `cpu_done` pulses with `cpu_rdata` equal to the `mem_rdata` word presented with `mem_rvalid`. `mem_rvalid` is honoured only in cycles after the command was accepted.
- R3: A request with `cpu_we`=1 produces exactly one memory command with `mem_cmd_we`=1 and the posted address, write data and size. `cpu_done` pulses after `mem_cmd_ready` accepts the command, and `cpu_rdata` keeps its previous value.
- R4: The payload is the one present on the CPU inputs in the cycle `cpu_req` is taken. Changes on those inputs afterwards do not alter the memory command.
- R5: Only one transaction is in flight at a time. `cpu_req` is ignored while `cpu_busy` is 1, and each accepted request yields exactly one memory command and one `cpu_done`. Both controllers step through their state codes one bit change at a time.
- R6: `cpu_busy` is 1 from the cycle after an accepted request until after that request's `cpu_done`. `cpu_done` is a one-cycle pulse and occurs only while `cpu_busy` is 1.
- R7: Once `mem_cmd_valid` is 1, it stays 1 with an unchanged command until the cycle in which `mem_cmd_ready` is 1.
- R8: Transactions complete correctly whether the memory clock is slower or faster than the CPU clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU domain clock |
| cpu_rst_n | input | 1 | CPU domain reset, active low, asynchronous |
| cpu_req | input | 1 | Post a transaction (taken when idle) |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Transaction address |
| cpu_wdata | input | DW | Write data |
| cpu_size | input | SW | Access size code, passed through |
| cpu_busy | output | 1 | Transaction in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Data of the most recent read |
| mem_clk | input | 1 | Memory domain clock |
| mem_rst_n | input | 1 | Memory domain reset, active low, asynchronous |
| mem_cmd_valid | output | 1 | Command presented |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_we | output | 1 | Command direction |
| mem_addr | output | AW | Command address |
| mem_wdata | output | DW | Command write data |
| mem_size | output | SW | Command size code |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DW | Returned read data |

## Verification
Reads and writes are interleaved over a small address range, so a read that follows a write to the same word shows whether the write data crossed intact. Accept delays from zero to several memory cycles check that the command is held while it waits. Read-return delays from zero upward separate correct waiting from early capture. Two runs differ in the direction of the clock ratio: one uses a memory clock slower than the CPU clock, the other a faster one. Each transaction also scrambles the CPU inputs and fires a second `cpu_req` while busy, which exposes any late capture of the payload and any accepted duplicate request.

// File: rtl/mem_xing_bridge.sv
module mem_xing_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          cpu_clk,
  input  logic          cpu_rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [SW-1:0] cpu_size,
  output logic          cpu_busy,
  output logic          cpu_done,
  output logic [DW-1:0] cpu_rdata,
  input  logic          mem_clk,
  input  logic          mem_rst_n,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic          mem_cmd_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [SW-1:0] mem_size,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);

  localparam int PW = 2 * SYNC_STAGES;

  localparam logic [1:0] C_IDLE = 2'b00;
  localparam logic [1:0] C_POST = 2'b01;
  localparam logic [1:0] C_ACK  = 2'b11;
  localparam logic [1:0] C_END  = 2'b10;

  localparam logic [1:0] M_IDLE = 2'b00;
  localparam logic [1:0] M_RUN  = 2'b01;
  localparam logic [1:0] M_DONE = 2'b11;
  localparam logic [1:0] M_REL  = 2'b10;

  logic [1:0]    c_st, m_st;
  logic [PW-1:0] c2m_pipe, m2c_pipe;
  logic [1:0]    c_seen_by_m, m_seen_by_c;

  logic          c_we;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic [SW-1:0] c_size;

  logic          m_sent;
  logic [DW-1:0] m_rdata_q;

  always_ff @(posedge mem_clk or negedge mem_rst_n)
    if (!mem_rst_n) c2m_pipe <= '0;
    else            c2m_pipe <= {c2m_pipe[PW-3:0], c_st};

  always_ff @(posedge cpu_clk or negedge cpu_rst_n)
    if (!cpu_rst_n) m2c_pipe <= '0;
    else            m2c_pipe <= {m2c_pipe[PW-3:0], m_st};

  assign c_seen_by_m = c2m_pipe[PW-1 -: 2];
  assign m_seen_by_c = m2c_pipe[PW-1 -: 2];

  assign cpu_busy = (c_st != C_IDLE);

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      c_st      <= C_IDLE;
      c_we      <= 1'b0;
      c_addr    <= '0;
      c_wdata   <= '0;
      c_size    <= '0;
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      case (c_st)
        C_IDLE: if (cpu_req) begin
          c_we    <= cpu_we;
          c_addr  <= cpu_addr;
          c_wdata <= cpu_wdata;
          c_size  <= cpu_size;
          c_st    <= C_POST;
        end
        C_POST: if (m_seen_by_c == M_DONE) begin
          if (!c_we) cpu_rdata <= m_rdata_q;
          cpu_done <= 1'b1;
          c_st     <= C_ACK;
        end
        C_ACK:  if (m_seen_by_c == M_IDLE) c_st <= C_END;
        default: c_st <= C_IDLE;
      endcase
    end
  end

  assign mem_cmd_valid = (m_st == M_RUN) && !m_sent;

  always_ff @(posedge mem_clk or negedge mem_rst_n) begin
    if (!mem_rst_n) begin
      m_st       <= M_IDLE;
      m_sent     <= 1'b0;
      mem_cmd_we <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_size   <= '0;
      m_rdata_q  <= '0;
    end else begin
      case (m_st)
        M_IDLE: if (c_seen_by_m == C_POST) begin
          mem_cmd_we <= c_we;
          mem_addr   <= c_addr;
          mem_wdata  <= c_wdata;
          mem_size   <= c_size;
          m_sent     <= 1'b0;
          m_st       <= M_RUN;
        end
        M_RUN: begin
          if (!m_sent && mem_cmd_ready) begin
            if (mem_cmd_we) m_st   <= M_DONE;
            else            m_sent <= 1'b1;
          end else if (m_sent && mem_rvalid) begin
            m_rdata_q <= mem_rdata;
            m_st      <= M_DONE;
          end
        end
        M_DONE: if (c_seen_by_m == C_ACK) m_st <= M_REL;
        default: m_st <= M_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mem_xing_bridge_chk.sv
module mem_xing_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2
) (
  input logic          cpu_clk,
  input logic          cpu_rst_n,
  input logic          mem_clk,
  input logic          mem_rst_n,
  input logic [1:0]    c_st,
  input logic [1:0]    m_st,
  input logic          cpu_busy,
  input logic          cpu_done,
  input logic [AW-1:0] c_addr,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic          mem_cmd_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [SW-1:0] mem_size
);

  AST_CPU_STATE_ONE_BIT: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $countones(c_st ^ $past(c_st)) <= 1); // R5

  AST_MEM_STATE_ONE_BIT: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
    $countones(m_st ^ $past(m_st)) <= 1); // R5

  AST_PAYLOAD_HELD: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (cpu_busy && $past(cpu_busy)) |-> $stable(c_addr)); // R4

  AST_DONE_PULSE: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_done |=> !cpu_done); // R6

  AST_DONE_WHILE_BUSY: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    cpu_done |-> cpu_busy); // R6

  AST_CMD_HOLD: assert property (@(posedge mem_clk) disable iff (!mem_rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_addr) &&
      $stable(mem_wdata) && $stable(mem_cmd_we) && $stable(mem_size))); // R7

endmodule

bind mem_xing_bridge mem_xing_bridge_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .mem_clk(mem_clk), .mem_rst_n(mem_rst_n),
  .c_st(c_st), .m_st(m_st), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .c_addr(c_addr),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_size(mem_size));

// File: tb/mem_xing_bridge_tb.sv
`timescale 1ns/1ps
module mem_xing_bridge_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 2;

  logic cpu_clk = 1'b0, mem_clk = 1'b0;
  logic cpu_rst_n = 1'b0, mem_rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [SW-1:0] cpu_size = '0;
  logic cpu_busy, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic mem_cmd_valid, mem_cmd_we;
  logic mem_cmd_ready = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [SW-1:0] mem_size;
  logic [DW-1:0] mem_rdata = '0;

  real mem_half = 6.15;
  always #4 cpu_clk = ~cpu_clk;
  always #(mem_half) mem_clk = ~mem_clk;

  mem_xing_bridge #(.AW(AW), .DW(DW), .SW(SW)) u_dut (
    .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_size(cpu_size),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_clk(mem_clk), .mem_rst_n(mem_rst_n), .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [SW-1:0] size;
  } cmd_t;

  int checks = 0, fails = 0;
  cmd_t exp_cmd[$];
  logic [DW-1:0] exp_rd[$];
  bit exp_isw[$];
  logic [DW-1:0] model [16];
  logic [DW-1:0] last_rd = '0;
  int cmd_count = 0;
  int ready_dly = 0, rd_dly = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // memory responder and command scoreboard
  initial begin
    forever begin
      @(negedge mem_clk);
      if (mem_rst_n && mem_cmd_valid) begin
        cmd_t got;
        got = {mem_cmd_we, mem_addr, mem_wdata, mem_size};
        for (int k = 0; k < ready_dly; k++) begin
          @(negedge mem_clk);
          chk(mem_cmd_valid && ({mem_cmd_we, mem_addr, mem_wdata, mem_size} == got), "R7",
              "command held until ready", 96'(mem_addr), 96'(got.addr));
        end
        mem_cmd_ready = 1'b1;
        @(negedge mem_clk);
        mem_cmd_ready = 1'b0;
        if (exp_cmd.size() == 0) begin
          chk(0, "R5", "unexpected memory command", 96'(got.addr), 96'(0));
        end else begin
          cmd_t e;
          e = exp_cmd.pop_front();
          chk(got == e, e.we ? "R3" : "R2", "memory command", 96'(got), 96'(e));
        end
        if (!got.we) begin
          for (int k = 0; k < rd_dly; k++) @(negedge mem_clk);
          mem_rdata  = model[got.addr[5:2]];
          mem_rvalid = 1'b1;
          @(negedge mem_clk);
          mem_rvalid = 1'b0;
          mem_rdata  = 32'h0BAD_0BAD;
        end else begin
          model[got.addr[5:2]] = got.wdata;
        end
        cmd_count++;
      end
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge cpu_clk);
      if (cpu_rst_n && cpu_done) begin
        chk(cpu_busy, "R6", "busy during done", 96'(cpu_busy), 96'(1));
        if (exp_rd.size() == 0) begin
          chk(0, "R5", "unexpected done", 96'(cpu_rdata), 96'(0));
        end else begin
          logic [DW-1:0] e;
          bit w;
          e = exp_rd.pop_front();
          w = exp_isw.pop_front();
          chk(cpu_rdata == e, w ? "R3" : "R2", w ? "rdata kept after write" : "read data",
              96'(cpu_rdata), 96'(e));
        end
      end
    end
  end

  task automatic txn(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wdata,
                     input logic [SW-1:0] size, input int rdy, input int rdd);
    logic [DW-1:0] e;
    int c0;
    while (cpu_busy) @(negedge cpu_clk);
    ready_dly = rdy;
    rd_dly    = rdd;
    c0 = cmd_count;
    e = we ? last_rd : model[addr[5:2]];
    if (!we) last_rd = e;
    exp_cmd.push_back({we, addr, wdata, size});
    exp_rd.push_back(e);
    exp_isw.push_back(we);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata; cpu_size = size;
    @(negedge cpu_clk);
    cpu_req = 1'b0; cpu_we = ~we; cpu_addr = ~addr; cpu_wdata = ~wdata; cpu_size = ~size; // R4
    chk(cpu_busy, "R6", "busy after request", 96'(cpu_busy), 96'(1));
    repeat (2) @(negedge cpu_clk);
    cpu_req = 1'b1; // R5 request while busy must be ignored
    @(negedge cpu_clk);
    cpu_req = 1'b0;
    while (cpu_busy) @(negedge cpu_clk);
    chk(cmd_count == c0 + 1, "R5", "one command per request", 96'(cmd_count), 96'(c0 + 1));
  endtask

  initial begin
    repeat (150000) @(posedge cpu_clk);
    chk(0, "watchdog", "run did not end", 96'(0), 96'(1));
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 32'hA500_0000 + 32'(i) * 32'h0001_1111;
    repeat (3) @(negedge cpu_clk);
    chk(!cpu_busy && !cpu_done && !mem_cmd_valid, "R1", "outputs during reset",
        96'({cpu_busy, cpu_done, mem_cmd_valid}), 96'(0));
    repeat (5) @(negedge cpu_clk);
    cpu_rst_n = 1'b1;
    mem_rst_n = 1'b1;
    repeat (4) @(negedge cpu_clk);
    chk(!cpu_busy && !cpu_done && !mem_cmd_valid, "R1", "outputs after reset",
        96'({cpu_busy, cpu_done, mem_cmd_valid}), 96'(0));
    chk(cpu_rdata == '0, "R1", "rdata after reset", 96'(cpu_rdata), 96'(0));

    // R8 memory clock slower than CPU clock
    txn(1'b0, 32'h04, 32'h0, 2'd2, 0, 0);
    txn(1'b1, 32'h08, 32'hDEAD_BEEF, 2'd2, 2, 0);
    txn(1'b0, 32'h08, 32'h0, 2'd2, 1, 3);
    txn(1'b1, 32'h0C, 32'h0000_0077, 2'd0, 0, 0);
    txn(1'b0, 32'h3C, 32'h0, 2'd1, 3, 4);
    txn(1'b0, 32'h0C, 32'h0, 2'd0, 0, 1);

    // R8 memory clock faster than CPU clock
    mem_half = 2.5;
    repeat (4) @(negedge cpu_clk);
    txn(1'b1, 32'h10, 32'h1234_5678, 2'd2, 0, 0);
    txn(1'b0, 32'h10, 32'h0, 2'd2, 4, 2);
    txn(1'b1, 32'h24, 32'hCAFE_F00D, 2'd1, 5, 0);
    txn(1'b0, 32'h00, 32'h0, 2'd2, 0, 5);
    txn(1'b0, 32'h24, 32'h0, 2'd1, 2, 0);

    // R8 much slower memory clock
    mem_half = 20.0;
    repeat (4) @(negedge cpu_clk);
    txn(1'b1, 32'h30, 32'h5555_AAAA, 2'd3, 1, 0);
    txn(1'b0, 32'h30, 32'h0, 2'd3, 0, 2);

    repeat (40) @(negedge cpu_clk);
    chk(exp_cmd.size() == 0 && exp_rd.size() == 0, "R5", "all transactions completed",
        96'(exp_cmd.size() + exp_rd.size()), 96'(0));
    finish_run();
  end
endmodule